// File: doc/BRIEF.md
# Status Register Write-Protection Unit

This unit keeps the eight-bit status byte of a serial flash device and rules on every memory-modifying command. The command decoder hands it one event per completed command: the command kind, the 22-bit target address and, for a status write, the data byte. The unit also samples the level of the active-low write-protect pin and a busy flag from the self-timed engine. For each event it answers with a one-cycle permit or deny pulse. It also emits a pulse whenever the event asks the write-enable latch to clear.

The protected region is always an upper slice of the array. Each step of a three-bit code halves or doubles that slice. Code 0 leaves the array open and code 7 protects all of it. A lock bit, together with a low write-protect pin, freezes the protection bits. While the pin stays low the lock can be set but never cleared. Erase and program requests are judged against the last byte they would touch. An erase that reaches into the protected slice is therefore refused.

Top module: `srwp_unit`

## Requirements
- R1: After reset the status byte reads 0x1C: lock bit 7 = 0, auto-increment bit 6 = 0, protection bits 5:2 = 0b0111, latch bit 1 = 0. Bit 0 always shows the busy input.
- R2: Protection codes use status bits 4:2 and ignore bit 5. Code 0 protects nothing. Codes 1 to 6 protect the top 1/64, 1/32, 1/16, 1/8, 1/4 and 1/2 of the 22-bit space. Code 7 protects the whole space. A byte program to a protected address is denied.
- R3: A write-enable event sets the latch. A write-disable event clears the latch and the auto-increment bit.
- R4: A status write is denied while the pin is low and the lock bit is 1. It is allowed while the pin is high, or while the lock bit is 0.
- R5: A permitted status write loads bit 7 and bits 5:2 from the data byte in one step, so lock and protection bits can change together. Data bits 6, 1 and 0 are ignored. While the pin is low, a lock bit of 1 never returns to 0.
- R6: A status write is permitted only directly after a permitted enable-status-write or write-enable event. Any other event in between, a status read included, disarms it. Every status-write event, permitted or not, clears the latch and pulses the latch-clear output.
- R7: Chip erase needs the latch and protection bits 5:2 all zero.
- R8: A sector erase covers 4 KB, a small block erase 32 KB and a large block erase 64 KB, aligned on their size. Low address bits are ignored. The erase is denied if the region's last byte is protected.
- R9: Erase and program events need the latch. A permitted one clears the latch and pulses the latch-clear output for one cycle. A denied one leaves the latch unchanged.
- R10: While busy is high, every event except a status read and the end of auto-increment is denied and changes no status bit.
- R11: A permitted auto-increment start sets bit 6 and keeps the latch. It checks the word address with bit 0 forced to 1. An auto-increment end event is always permitted and clears bit 6 and the latch.
- R12: Event kinds: 1 write-enable, 2 write-disable, 3 enable-status-write, 4 status write, 5 sector erase, 6 small block erase, 7 large block erase, 8 chip erase, 9 byte program, 10 auto-increment start, 11 auto-increment end, 12 status read. Kind 0 and kinds 13 to 15 are denied. The decision appears on permit or deny in the cycle after the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | One-cycle strobe marking a completed command |
| ev_kind | input | 4 | Command kind (R12 encoding) |
| ev_addr | input | 22 | Target byte address |
| ev_data | input | 8 | Data byte of a status write |
| wp_n | input | 1 | Write-protect pin level, active low |
| busy_in | input | 1 | Self-timed operation in progress |
| status_o | output | 8 | Status byte for reads |
| permit_o | output | 1 | Event was accepted (one cycle) |
| deny_o | output | 1 | Event was refused (one cycle) |
| wel_clr_o | output | 1 | Latch-clear request pulse |

## Verification
Several rules are checked by assertions on every cycle:
- a locked status write under a low pin is refused;
- the lock bit cannot fall while the pin is low;
- chip erase with nonzero protection is refused;
- busy refuses the gated events;
- a status write always leaves the latch clear.

Other behaviour shows only in the bench's scenarios:
- the decode boundaries of each protection code;
- the overlap of erase regions with the protected slice;
- the disarming of a status write by an intervening event;
- the read-only status bits.

// File: rtl/srwp_pkg.sv
// Shared event encoding and status bit positions for the write-protection unit.
// Assumes the command decoder uses exactly this kind numbering.
package srwp_pkg;
    typedef enum logic [3:0] {
        EV_NOP        = 4'd0,
        EV_WREN       = 4'd1,
        EV_WRDI       = 4'd2,
        EV_ARM_SR     = 4'd3,
        EV_WRITE_SR   = 4'd4,
        EV_ERASE_SECT = 4'd5,
        EV_ERASE_B32  = 4'd6,
        EV_ERASE_B64  = 4'd7,
        EV_ERASE_CHIP = 4'd8,
        EV_PROG_BYTE  = 4'd9,
        EV_AAI_START  = 4'd10,
        EV_AAI_END    = 4'd11,
        EV_READ_SR    = 4'd12
    } ev_kind_e;

    localparam int SB_BUSY = 0;
    localparam int SB_WEL  = 1;
    localparam int SB_BP_LO = 2;
    localparam int SB_BP_HI = 5;
    localparam int SB_MODE = 6;
    localparam int SB_LOCK = 7;
    localparam logic [7:0] SR_RESET = 8'h1C;
endpackage

// File: rtl/srwp_region_check.sv
// Decides whether the last byte of an addressed region lies in the protected
// upper slice. Assumes regions are power-of-two sized and size-aligned, so the
// last byte is the address with its low span bits forced high.
module srwp_region_check #(
    parameter int ADDR_W   = 22,
    parameter int SPAN_W   = 5,
    parameter int FRAC_MAX = 6
) (
    input  logic [2:0]        bp_code,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SPAN_W-1:0] span_lg,
    output logic              prot_o
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] last_byte;
    logic              frac_hit;
    int                top_bits;

    // Last byte touched by the region.
    always_comb last_byte = addr | ((ONE << span_lg) - ONE);

    // Top-slice test: the top (7 - code) address bits must all be ones.
    always_comb begin
        top_bits = 7 - int'(bp_code);
        frac_hit = 1'b1;
        for (int i = 0; i < FRAC_MAX; i++) begin
            if (i < top_bits) frac_hit = frac_hit & last_byte[ADDR_W-1-i];
        end
    end

    // Code 0 opens everything, code 7 closes everything.
    always_comb begin
        case (bp_code)
            3'd0:    prot_o = 1'b0;
            3'd7:    prot_o = 1'b1;
            default: prot_o = frac_hit;
        endcase
    end
endmodule

// File: rtl/srwp_status_reg.sv
// Holds the writable and internally driven status bits. Assumes the arbiter
// never raises a set and a clear of the same bit in one cycle.
module srwp_status_reg
    import srwp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_sr,
    input  logic       wr_lock,
    input  logic [3:0] wr_bp,
    input  logic       set_wel,
    input  logic       clr_wel,
    input  logic       set_mode,
    input  logic       clr_mode,
    input  logic       busy_in,
    output logic [7:0] status_o
);
    logic       lock_q, wel_q, mode_q;
    logic [3:0] bp_q;

    // Lock and protection bits, loaded only by a permitted status write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= SR_RESET[SB_LOCK];
            bp_q   <= SR_RESET[SB_BP_HI:SB_BP_LO];
        end else if (wr_sr) begin
            lock_q <= wr_lock;
            bp_q   <= wr_bp;
        end
    end

    // Write-enable latch.
    always_ff @(posedge clk) begin
        if (!rst_n)       wel_q <= 1'b0;
        else if (set_wel) wel_q <= 1'b1;
        else if (clr_wel) wel_q <= 1'b0;
    end

    // Auto-increment mode bit.
    always_ff @(posedge clk) begin
        if (!rst_n)        mode_q <= 1'b0;
        else if (set_mode) mode_q <= 1'b1;
        else if (clr_mode) mode_q <= 1'b0;
    end

    // Status byte assembly; busy passes straight through.
    always_comb status_o = {lock_q, mode_q, bp_q, wel_q, busy_in};
endmodule

// File: rtl/srwp_arbiter.sv
// Rules on each command event against the latch, lock, protection and busy
// state and issues register updates. Decisions are registered one cycle late.
module srwp_arbiter
    import srwp_pkg::*;
#(
    parameter int SPAN_W   = 5,
    parameter int SECT_LG  = 12,
    parameter int BLK32_LG = 15,
    parameter int BLK64_LG = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [3:0]        ev_kind,
    input  logic              wp_n,
    input  logic              busy_in,
    input  logic              lock,
    input  logic [3:0]        bp,
    input  logic              wel,
    input  logic              region_prot,
    output logic [SPAN_W-1:0] span_lg,
    output logic              wr_sr,
    output logic              set_wel,
    output logic              clr_wel,
    output logic              set_mode,
    output logic              clr_mode,
    output logic              permit_o,
    output logic              deny_o,
    output logic              wel_clr_o
);
    ev_kind_e kind;
    logic     ok, arm_next, armed_q;

    always_comb kind = ev_kind_e'(ev_kind);

    // Region size handed to the protection check for this kind.
    always_comb begin
        case (kind)
            EV_ERASE_SECT: span_lg = SPAN_W'(SECT_LG);
            EV_ERASE_B32:  span_lg = SPAN_W'(BLK32_LG);
            EV_ERASE_B64:  span_lg = SPAN_W'(BLK64_LG);
            EV_AAI_START:  span_lg = SPAN_W'(1);
            default:       span_lg = '0;
        endcase
    end

    // Decision and register-update requests for the current event.
    always_comb begin
        ok = 1'b0; arm_next = 1'b0; wr_sr = 1'b0;
        set_wel = 1'b0; clr_wel = 1'b0; set_mode = 1'b0; clr_mode = 1'b0;
        if (ev_valid) begin
            case (kind)
                EV_READ_SR:  ok = 1'b1;
                EV_WREN: begin
                    ok = !busy_in; set_wel = ok; arm_next = ok;
                end
                EV_WRDI: begin
                    ok = !busy_in; clr_wel = ok; clr_mode = ok;
                end
                EV_ARM_SR: begin
                    ok = !busy_in; arm_next = ok;
                end
                EV_WRITE_SR: begin
                    ok = !busy_in && armed_q && (wp_n || !lock);
                    wr_sr = ok; clr_wel = 1'b1;
                end
                EV_ERASE_SECT, EV_ERASE_B32, EV_ERASE_B64, EV_PROG_BYTE: begin
                    ok = !busy_in && wel && !region_prot; clr_wel = ok;
                end
                EV_ERASE_CHIP: begin
                    ok = !busy_in && wel && (bp == 4'd0); clr_wel = ok;
                end
                EV_AAI_START: begin
                    ok = !busy_in && wel && !region_prot; set_mode = ok;
                end
                EV_AAI_END: begin
                    ok = 1'b1; clr_wel = 1'b1; clr_mode = 1'b1;
                end
                default: ok = 1'b0;
            endcase
        end
    end

    // Arming for a status write lasts exactly until the next event.
    always_ff @(posedge clk) begin
        if (!rst_n)        armed_q <= 1'b0;
        else if (ev_valid) armed_q <= arm_next;
    end

    // Registered decision and latch-clear pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            permit_o <= 1'b0; deny_o <= 1'b0; wel_clr_o <= 1'b0;
        end else begin
            permit_o  <= ev_valid && ok;
            deny_o    <= ev_valid && !ok;
            wel_clr_o <= clr_wel;
        end
    end

    // R4: locked status write under a low pin is refused.
    assert_locked_write_denied_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && kind == EV_WRITE_SR && !wp_n && lock) |=> deny_o);

    // R7: chip erase with any protection bit set is refused.
    assert_chip_erase_bp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && kind == EV_ERASE_CHIP && bp != 4'd0) |=> deny_o);

    // R10: busy refuses every gated event.
    assert_busy_denies_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && busy_in && kind != EV_READ_SR && kind != EV_AAI_END) |=> deny_o);
endmodule

// File: rtl/srwp_unit.sv
// Top of the status register write-protection unit: connects the arbiter,
// the status register and the protected-region decode.
module srwp_unit
    import srwp_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int SECT_LG  = 12,
    parameter int BLK32_LG = 15,
    parameter int BLK64_LG = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [3:0]        ev_kind,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [7:0]        ev_data,
    input  logic              wp_n,
    input  logic              busy_in,
    output logic [7:0]        status_o,
    output logic              permit_o,
    output logic              deny_o,
    output logic              wel_clr_o
);
    localparam int SPAN_W = $clog2(ADDR_W + 1);

    logic [SPAN_W-1:0] span_lg;
    logic region_prot, wr_sr, set_wel, clr_wel, set_mode, clr_mode;
    logic unused_data_bits;

    // Data bits 6, 1 and 0 have no writable destination.
    always_comb unused_data_bits = ^{ev_data[6], ev_data[1:0]};

    srwp_region_check #(.ADDR_W(ADDR_W), .SPAN_W(SPAN_W), .FRAC_MAX(6)) i_region (
        .bp_code (status_o[4:2]),
        .addr    (ev_addr),
        .span_lg (span_lg),
        .prot_o  (region_prot)
    );

    srwp_arbiter #(.SPAN_W(SPAN_W), .SECT_LG(SECT_LG), .BLK32_LG(BLK32_LG),
                   .BLK64_LG(BLK64_LG)) i_arbiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_valid    (ev_valid),
        .ev_kind     (ev_kind),
        .wp_n        (wp_n),
        .busy_in     (busy_in),
        .lock        (status_o[SB_LOCK]),
        .bp          (status_o[SB_BP_HI:SB_BP_LO]),
        .wel         (status_o[SB_WEL]),
        .region_prot (region_prot),
        .span_lg     (span_lg),
        .wr_sr       (wr_sr),
        .set_wel     (set_wel),
        .clr_wel     (clr_wel),
        .set_mode    (set_mode),
        .clr_mode    (clr_mode),
        .permit_o    (permit_o),
        .deny_o      (deny_o),
        .wel_clr_o   (wel_clr_o)
    );

    srwp_status_reg i_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sr    (wr_sr),
        .wr_lock  (ev_data[7]),
        .wr_bp    (ev_data[5:2]),
        .set_wel  (set_wel),
        .clr_wel  (clr_wel),
        .set_mode (set_mode),
        .clr_mode (clr_mode),
        .busy_in  (busy_in),
        .status_o (status_o)
    );

    // R5: with the pin low a set lock bit stays set.
    assert_lock_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n && status_o[SB_LOCK]) |=> status_o[SB_LOCK]);

    // R6: any status-write event leaves the latch clear.
    assert_wrsr_clears_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind == EV_WRITE_SR) |=> !status_o[SB_WEL]);
endmodule

// File: tb/test_srwp_unit.sv
// Self-checking bench: a vector table walked in order, then directed tests.
module test_srwp_unit;
    localparam int AW = 22;
    localparam time TCLK = 20ns;

    typedef struct packed {
        logic [3:0]    kind;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        logic          wp;
        logic          busy;
        logic          perm;
        logic [7:0]    stat;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 49;
    localparam vec_t TBL [NV] = '{
        '{4'd12, 22'h0,      8'h00, 1'b1, 1'b0, 1'b1, 8'h1C, 4'd1},  // R1 read after reset
        '{4'd4,  22'h0,      8'h00, 1'b1, 1'b0, 1'b0, 8'h1C, 4'd6},  // R6 unarmed write
        '{4'd3,  22'h0,      8'h00, 1'b1, 1'b0, 1'b1, 8'h1C, 4'd6},
        '{4'd4,  22'h0,      8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 4'd6},
        '{4'd5,  22'h0,      8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 4'd9},  // R9 no latch
        '{4'd1,  22'h0,      8'h00, 1'b1, 1'b0, 1'b1, 8'h02, 4'd3},  // R3
        '{4'd5,  22'h000123, 8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 4'd9},
        '{4'd1,  22'h0,      8'h00, 1'b1, 1'b0, 1'b1, 8'h02, 4'd3},
        '{4'd4,  22'h0,      8'h04, 1'b1, 1'b0, 1'b1, 8'h04, 4'd6},  // armed by write-enable
        '{4'd1,  22'h0,      8'h00, 1'b1, 1'b0, 1'b1, 8'h06, 4'd3},
        '{4'd9,  22'h3F0000, 8'h00, 1'b1, 1'b0, 1'b0, 8'h06, 4'd2},  // R2 top 1/64
        '{4'd9,  22'h3EFFFF, 8'h00, 1'b1, 1'b0, 1'b1, 8'h04, 4'd2},
        '{4'd1,  22'h0,      8'h00, 1'b1, 1'b0, 1'b1, 8'h06, 4'd3},
        '{4'd7,  22'h3E0000, 8'h00, 1'b1, 1'b0, 1'b1, 8'h04, 4'd8},  // R8
        '{4'd1,  22'h0,      8'h00, 1'b1, 1'b0, 1'b1, 8'h06, 4'd3},
        '{4'd7,  22'h3F1234, 8'h00, 1'b1, 1'b0, 1'b0, 8'h06, 4'd8},
        '{4'd8,  22'h0,      8'h00, 1'b1, 1'b0, 1'b0, 8'h06, 4'd7},  // R7
        '{4'd6,  22'h3F8000, 8'h00, 1'b1, 1'b0, 1'b0, 8'h06, 4'd8},
        '{4'd6,  22'h3E8000, 8'h00, 1'b1, 1'b0, 1'b1, 8'h04, 4'd8},
        '{4'd3,  22'h0,      8'h00, 1'b1, 1'b0, 1'b1, 8'h04, 4'd6},
        '{4'd4,  22'h0,      8'h98, 1'b1, 1'b0, 1'b1, 8'h98, 4'd5},  // R5 lock+bp together
        '{4'd1,  22'h0,      8'h00, 1'b0, 1'b0, 1'b1, 8'h9A, 4'd3},
        '{4'd9,  22'h1FFFFF, 8'h00, 1'b0, 1'b0, 1'b1, 8'h98, 4'd2},  // R2 top 1/2 edge
        '{4'd3,  22'h0,      8'h00, 1'b0, 1'b0, 1'b1, 8'h98, 4'd4},
        '{4'd4,  22'h0,      8'h00, 1'b0, 1'b0, 1'b0, 8'h98, 4'd4},  // R4 locked
        '{4'd3,  22'h0,      8'h00, 1'b1, 1'b0, 1'b1, 8'h98, 4'd4},
        '{4'd4,  22'h0,      8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 4'd4},  // R4 pin high
        '{4'd3,  22'h0,      8'h00, 1'b0, 1'b0, 1'b1, 8'h00, 4'd5},
        '{4'd4,  22'h0,      8'h9C, 1'b0, 1'b0, 1'b1, 8'h9C, 4'd5},  // R5 set lock, pin low
        '{4'd1,  22'h0,      8'h00, 1'b1, 1'b0, 1'b1, 8'h9E, 4'd3},
        '{4'd9,  22'h000000, 8'h00, 1'b1, 1'b0, 1'b0, 8'h9E, 4'd2},  // R2 code 7
        '{4'd1,  22'h0,      8'h00, 1'b1, 1'b1, 1'b0, 8'h9F, 4'd10}, // R10
        '{4'd12, 22'h0,      8'h00, 1'b1, 1'b1, 1'b1, 8'h9F, 4'd10},
        '{4'd3,  22'h0,      8'h00, 1'b1, 1'b0, 1'b1, 8'h9E, 4'd6},
        '{4'd4,  22'h0,      8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 4'd6},
        '{4'd1,  22'h0,      8'h00, 1'b1, 1'b0, 1'b1, 8'h02, 4'd3},
        '{4'd10, 22'h001000, 8'h00, 1'b1, 1'b0, 1'b1, 8'h42, 4'd11}, // R11
        '{4'd11, 22'h0,      8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 4'd11},
        '{4'd1,  22'h0,      8'h00, 1'b1, 1'b0, 1'b1, 8'h02, 4'd3},
        '{4'd2,  22'h0,      8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 4'd3},
        '{4'd1,  22'h0,      8'h00, 1'b1, 1'b0, 1'b1, 8'h02, 4'd3},
        '{4'd8,  22'h0,      8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 4'd7},
        '{4'd4,  22'h0,      8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 4'd6},
        '{4'd3,  22'h0,      8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 4'd6},
        '{4'd4,  22'h0,      8'h47, 1'b1, 1'b0, 1'b1, 8'h04, 4'd5},  // R5 read-only bits
        '{4'd3,  22'h0,      8'h00, 1'b1, 1'b0, 1'b1, 8'h04, 4'd6},
        '{4'd12, 22'h0,      8'h00, 1'b1, 1'b0, 1'b1, 8'h04, 4'd6},
        '{4'd4,  22'h0,      8'h00, 1'b1, 1'b0, 1'b0, 8'h04, 4'd6},  // R6 read disarms
        '{4'd15, 22'h0,      8'h00, 1'b1, 1'b0, 1'b0, 8'h04, 4'd12}  // R12 bad kind
    };

    logic clk = 1'b0, rst_n = 1'b0, ev_valid = 1'b0, wp_n = 1'b1, busy_in = 1'b0;
    logic [3:0] ev_kind = '0;
    logic [AW-1:0] ev_addr = '0;
    logic [7:0] ev_data = '0;
    logic [7:0] status_o;
    logic permit_o, deny_o, wel_clr_o;
    int n_checks = 0, n_fail = 0;
    bit finished = 1'b0;

    always #(TCLK/2) clk = ~clk;

    srwp_unit i_srwp_unit (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_addr(ev_addr), .ev_data(ev_data), .wp_n(wp_n), .busy_in(busy_in),
        .status_o(status_o), .permit_o(permit_o), .deny_o(deny_o), .wel_clr_o(wel_clr_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one event for one cycle; returns at the following falling edge.
    task automatic send(input logic [3:0] k, input logic [AW-1:0] a, input logic [7:0] d,
                        input logic wp, input logic bz);
        @(negedge clk);
        ev_kind = k; ev_addr = a; ev_data = d; wp_n = wp; busy_in = bz; ev_valid = 1'b1;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; busy_in = 1'b0; wp_n = 1'b1;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R1: reset value and idle outputs.
        check("R1 reset status", {8'h0, status_o}, 16'h001C);
        check("R1 idle decision", {14'h0, permit_o, deny_o}, 16'h0);

        // Table walk; covers R2 to R12.
        for (int i = 0; i < NV; i++) begin
            send(TBL[i].kind, TBL[i].addr, TBL[i].data, TBL[i].wp, TBL[i].busy);
            check($sformatf("R%0d vector %0d", TBL[i].req, i),
                  {6'h0, permit_o, deny_o, status_o},
                  {6'h0, TBL[i].perm, !TBL[i].perm, TBL[i].stat});
        end
        busy_in = 1'b0;

        // R1: busy bit follows the input without delay.
        @(negedge clk); busy_in = 1'b1; #1;
        check("R1 busy bit", {15'h0, status_o[0]}, 16'h1);
        busy_in = 1'b0;

        // R9: denied erase keeps latch, no clear pulse; permitted one pulses once.
        do_reset();
        send(4'd1, '0, 8'h00, 1'b1, 1'b0);
        send(4'd5, 22'h000000, 8'h00, 1'b1, 1'b0);
        check("R9 denied erase keeps latch", {7'h0, wel_clr_o, status_o}, {8'h0, 8'h1E});
        send(4'd3, '0, 8'h00, 1'b1, 1'b0);
        send(4'd4, '0, 8'h00, 1'b1, 1'b0);
        check("R6 status write clear pulse", {7'h0, wel_clr_o, status_o}, {8'h1, 8'h00});
        send(4'd1, '0, 8'h00, 1'b1, 1'b0);
        send(4'd6, 22'h123456, 8'h00, 1'b1, 1'b0);
        check("R9 erase clear pulse", {7'h0, wel_clr_o, status_o}, {8'h1, 8'h00});
        @(negedge clk);
        check("R9 pulse one cycle", {14'h0, wel_clr_o, permit_o}, 16'h0);

        // R11: auto-increment on the last word of an open space, then write-disable.
        send(4'd1, '0, 8'h00, 1'b1, 1'b0);
        send(4'd10, 22'h3FFFFE, 8'h00, 1'b1, 1'b0);
        check("R11 start sets mode", {8'h0, status_o}, 16'h0042);
        send(4'd2, '0, 8'h00, 1'b1, 1'b0);
        check("R3 disable clears mode", {8'h0, status_o}, 16'h0000);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(TCLK * 20000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule